// File: doc/BRIEF.md
# Latency-pair issue interlock

This block decides, cycle by cycle, whether the instruction sitting in decode of an in-order five-stage pipeline may issue. It is given the class of that instruction, its destination register and up to two source registers. It holds a small countdown for every integer and every floating-point register. The countdown says how many more cycles must pass before a pending result may be consumed. The block computes nothing on data and controls no forwarding paths. Its only output to the pipeline is a stall line. It also keeps a running count of the stall cycles it has inserted.

How long the interlock waits depends on both ends of the dependence. It is not one fixed load-use bubble. An integer result is free to a following integer instruction but costs one cycle before a branch. Results of a floating-point load, add or multiply become usable by a floating-point operation after different delays. All functional units are pipelined with an initiation interval of one, so the only hazards modelled are true data dependences. A correctly predicted branch takes one issue slot and nothing more.

The pipeline in front holds the decode instruction in place while `stall` is high and presents it again in the next cycle.

Top module: `ilk_interlock`

## Requirements
- R1: Class codes are 0 integer ALU, 1 branch, 2 FP load, 3 FP add, 4 FP multiply. An integer ALU result can be used with no stall by an integer ALU instruction or by an FP load that names it as its base source, in the cycle right after the producer issues.
- R2: A branch that reads the destination of an integer ALU instruction issued in the previous cycle stalls for exactly 1 cycle.
- R3: An FP add or FP multiply that reads the destination of an FP load stalls for exactly 1 cycle when it directly follows that load.
- R4: An FP add or FP multiply that reads the destination of an FP add stalls for exactly 3 cycles when it directly follows it.
- R5: An FP add or FP multiply that reads the destination of an FP multiply stalls for exactly 4 cycles when it directly follows it.
- R6: Integer and FP registers are tracked apart. Integer ALU, branch and FP load read integer sources. FP add and FP multiply read FP sources. Integer ALU writes an integer register. FP load, add and multiply write an FP register. A pending write to one file never stalls a reader of the same index in the other file.
- R7: A source whose enable input is low is never waited on. A branch marks no destination as pending.
- R8: When a register is written again while still pending, it becomes ready at the later of the two completion times.
- R9: Countdowns run down in every cycle, including cycles with no valid instruction and stalled cycles. When `dec_valid` is low, `stall` is low.
- R10: Class codes 5 to 7 never stall and mark no register as pending.
- R11: `stall_cycles` rises by one after every clock edge at which `stall` was high and otherwise holds.
- R12: A synchronous active-high reset makes every register ready and clears `stall_cycles` to 0.
- R13: A stalled instruction marks its destination only in the cycle it finally issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_class | input | 3 | Class code of the decode instruction |
| dec_dst | input | IW (5) | Destination register index |
| dec_src_a | input | IW (5) | First source register index |
| dec_src_a_en | input | 1 | First source is used |
| dec_src_b | input | IW (5) | Second source register index |
| dec_src_b_en | input | 1 | Second source is used |
| stall | output | 1 | Hold the decode instruction this cycle |
| stall_cycles | output | SCW (16) | Stall cycles inserted since reset |

## Verification
The bench goes after each producer and consumer pair at distance one. A single fixed bubble length would give the wrong count for at least one pair. The branch case and the integer-to-integer case tell a design that ignores the consumer class apart from one that honours it. Same-index reads across the two register files catch a shared scoreboard, which would insert stalls that should not happen. Two cases catch a bad pending mark. A rewrite of a pending register by a faster unit catches a design that shortens the wait. An instruction that is itself stalled before it produces catches a design that marks its destination too early and so releases its consumer too soon. Idle gaps, reserved codes and a mid-run reset show whether countdowns keep running and are cleared. A long randomised stream against a ready-time model checks everything else.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam logic [2:0] CLS_INT  = 3'd0;
    localparam logic [2:0] CLS_BR   = 3'd1;
    localparam logic [2:0] CLS_FLD  = 3'd2;
    localparam logic [2:0] CLS_FADD = 3'd3;
    localparam logic [2:0] CLS_FMUL = 3'd4;

    localparam int FILE_INT = 0;
    localparam int FILE_FP  = 1;
    localparam int NFILES   = 2;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ilk_ready_file.sv
module ilk_ready_file #(
    parameter int NREG = 32,
    parameter int IW   = $clog2(NREG),
    parameter int CW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [CW-1:0] wr_lat,
    input  logic [IW-1:0] rd_a_idx,
    input  logic [IW-1:0] rd_b_idx,
    output logic [CW-1:0] rem_a,
    output logic [CW-1:0] rem_b
);

    logic [NREG-1:0][CW-1:0] cnt_d, cnt_q;

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            logic [CW-1:0] dn;
            dn = (cnt_q[i] != '0) ? cnt_q[i] - 1'b1 : '0;
            if (wr_en && (wr_idx == IW'(i)) && (wr_lat > dn)) begin
                cnt_d[i] = wr_lat;
            end else begin
                cnt_d[i] = dn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign rem_a = cnt_q[rd_a_idx];
    assign rem_b = cnt_q[rd_b_idx];

endmodule

// File: rtl/ilk_lat_decode.sv
module ilk_lat_decode
    import ilk_pkg::*;
#(
    parameter int CW      = 3,
    parameter int LAT_II  = 0,
    parameter int LAT_IB  = 1,
    parameter int LAT_LD  = 1,
    parameter int LAT_ADD = 3,
    parameter int LAT_MUL = 4
) (
    input  logic [2:0]    cls,
    output logic          known,
    output logic          src_fp,
    output logic          wr_int,
    output logic          wr_fp,
    output logic [CW-1:0] wr_lat,
    output logic [CW-1:0] thr
);

    localparam int LINT = imax(LAT_II, LAT_IB);

    always_comb begin
        known  = 1'b1;
        src_fp = 1'b0;
        wr_int = 1'b0;
        wr_fp  = 1'b0;
        wr_lat = '0;
        thr    = '0;
        case (cls)
            CLS_INT: begin
                wr_int = 1'b1;
                wr_lat = CW'(LINT);
                thr    = CW'(LINT - LAT_II);
            end
            CLS_BR: begin
                thr    = CW'(LINT - LAT_IB);
            end
            CLS_FLD: begin
                wr_fp  = 1'b1;
                wr_lat = CW'(LAT_LD);
                thr    = CW'(LINT - LAT_II);
            end
            CLS_FADD: begin
                src_fp = 1'b1;
                wr_fp  = 1'b1;
                wr_lat = CW'(LAT_ADD);
            end
            CLS_FMUL: begin
                src_fp = 1'b1;
                wr_fp  = 1'b1;
                wr_lat = CW'(LAT_MUL);
            end
            default: begin
                known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
    import ilk_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int IW      = $clog2(NREG),
    parameter int SCW     = 16,
    parameter int LAT_II  = 0,
    parameter int LAT_IB  = 1,
    parameter int LAT_LD  = 1,
    parameter int LAT_ADD = 3,
    parameter int LAT_MUL = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           dec_valid,
    input  logic [2:0]     dec_class,
    input  logic [IW-1:0]  dec_dst,
    input  logic [IW-1:0]  dec_src_a,
    input  logic           dec_src_a_en,
    input  logic [IW-1:0]  dec_src_b,
    input  logic           dec_src_b_en,
    output logic           stall,
    output logic [SCW-1:0] stall_cycles
);

    localparam int MAXL = imax(imax(imax(LAT_II, LAT_IB), imax(LAT_LD, LAT_ADD)), LAT_MUL);
    localparam int CW   = (MAXL < 1) ? 1 : $clog2(MAXL + 1);

    typedef struct packed {
        logic [SCW-1:0] stall_cnt;
    } ilk_state_t;

    ilk_state_t st_d, st_q;

    logic          known, src_fp, wr_int, wr_fp;
    logic [CW-1:0] wr_lat, thr;
    logic [CW-1:0] rem_a, rem_b;
    logic          issue;

    logic [NFILES-1:0]         file_wr;
    logic [NFILES-1:0][CW-1:0] file_rem_a, file_rem_b;

    ilk_lat_decode #(
        .CW(CW), .LAT_II(LAT_II), .LAT_IB(LAT_IB),
        .LAT_LD(LAT_LD), .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL)
    ) i_dec (
        .cls    (dec_class),
        .known  (known),
        .src_fp (src_fp),
        .wr_int (wr_int),
        .wr_fp  (wr_fp),
        .wr_lat (wr_lat),
        .thr    (thr)
    );

    assign file_wr[FILE_INT] = issue && wr_int;
    assign file_wr[FILE_FP]  = issue && wr_fp;

    for (genvar g = 0; g < NFILES; g++) begin : g_file
        ilk_ready_file #(.NREG(NREG), .IW(IW), .CW(CW)) i_file (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (file_wr[g]),
            .wr_idx   (dec_dst),
            .wr_lat   (wr_lat),
            .rd_a_idx (dec_src_a),
            .rd_b_idx (dec_src_b),
            .rem_a    (file_rem_a[g]),
            .rem_b    (file_rem_b[g])
        );
    end

    always_comb begin
        rem_a = src_fp ? file_rem_a[FILE_FP] : file_rem_a[FILE_INT];
        rem_b = src_fp ? file_rem_b[FILE_FP] : file_rem_b[FILE_INT];
        stall = dec_valid && known &&
                ((dec_src_a_en && (rem_a > thr)) || (dec_src_b_en && (rem_b > thr)));
        issue = dec_valid && !stall;
        st_d  = st_q;
        if (stall) begin
            st_d.stall_cnt = st_q.stall_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall_cycles = st_q.stall_cnt;

endmodule

// File: rtl/ilk_interlock_chk.sv
module ilk_interlock_chk #(
    parameter int SCW = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           dec_valid,
    input logic [2:0]     dec_class,
    input logic           stall,
    input logic [SCW-1:0] stall_cycles
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    p_idle_no_stall_r9: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !stall);

    p_reserved_no_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (dec_class > 3'd4) |-> !stall);

    p_count_step_r11: assert property (@(posedge clk) disable iff (rst)
        stall |=> (stall_cycles == $past(stall_cycles) + 1'b1));

    p_count_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !stall |=> $stable(stall_cycles));

    p_reset_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (rst_q === 1'b1) |-> (stall_cycles == '0));

endmodule

bind ilk_interlock ilk_interlock_chk #(.SCW(SCW)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .dec_valid    (dec_valid),
    .dec_class    (dec_class),
    .stall        (stall),
    .stall_cycles (stall_cycles)
);

// File: tb/test_ilk_interlock.sv
module test_ilk_interlock;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 1'b0;
    logic [2:0]  dec_class = '0;
    logic [4:0]  dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
    logic        dec_src_a_en = 1'b0, dec_src_b_en = 1'b0;
    logic        stall;
    logic [15:0] stall_cycles;

    int checks = 0;
    int errors = 0;

    int rdy_int [32];
    int rdy_br  [32];
    int rdy_fp  [32];
    int tnow = 0;
    int m_sc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilk_interlock i_ilk_interlock (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_class(dec_class),
        .dec_dst(dec_dst), .dec_src_a(dec_src_a), .dec_src_a_en(dec_src_a_en),
        .dec_src_b(dec_src_b), .dec_src_b_en(dec_src_b_en),
        .stall(stall), .stall_cycles(stall_cycles)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0d", req, act, exp_v, tnow);
        end
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int lat_of(input logic [2:0] c);
        case (c)
            3'd2: return 1;
            3'd3: return 3;
            default: return 4;
        endcase
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 32; i++) begin
            rdy_int[i] = 0; rdy_br[i] = 0; rdy_fp[i] = 0;
        end
        m_sc = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; dec_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // One clock: checks the counter and the stall line against the model.
    task automatic cycle(input logic v, input logic [2:0] c, input logic [4:0] d,
                         input logic [4:0] a, input logic ae,
                         input logic [4:0] b, input logic be,
                         input string req, output bit issued, output bit stalled);
        bit es;
        @(negedge clk);
        chk("R11 counter", int'(stall_cycles), m_sc % 65536);
        dec_valid = v; dec_class = c; dec_dst = d;
        dec_src_a = a; dec_src_a_en = ae; dec_src_b = b; dec_src_b_en = be;
        #1;
        es = 1'b0;
        if (v) begin
            case (c)
                3'd0, 3'd2: es = (ae && tnow < rdy_int[a]) || (be && tnow < rdy_int[b]);
                3'd1:       es = (ae && tnow < rdy_br[a])  || (be && tnow < rdy_br[b]);
                3'd3, 3'd4: es = (ae && tnow < rdy_fp[a])  || (be && tnow < rdy_fp[b]);
                default:    es = 1'b0;
            endcase
        end
        chk(req, int'(stall), int'(es));
        if (v && !es) begin
            case (c)
                3'd0: begin
                    rdy_int[d] = mx(rdy_int[d], tnow + 1);
                    rdy_br[d]  = mx(rdy_br[d], tnow + 2);
                end
                3'd2, 3'd3, 3'd4: rdy_fp[d] = mx(rdy_fp[d], tnow + 1 + lat_of(c));
                default: ;
            endcase
        end
        if (es) m_sc++;
        issued  = v && !es;
        stalled = es;
        tnow++;
    endtask

    // Presents one instruction until it issues; returns stall cycles spent.
    task automatic run(input logic [2:0] c, input logic [4:0] d,
                       input logic [4:0] a, input logic ae,
                       input logic [4:0] b, input logic be,
                       input string req, output int nst);
        bit iss, stl;
        nst = 0;
        for (int k = 0; k < 20; k++) begin
            cycle(1'b1, c, d, a, ae, b, be, req, iss, stl);
            if (iss) break;
            nst++;
        end
    endtask

    task automatic idle(input int n);
        bit iss, stl;
        for (int k = 0; k < n; k++) cycle(1'b0, 3'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, "R9 idle", iss, stl);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, base;
        bit iss, stl;
        model_clear();
        do_reset();
        #1;
        chk("R12 reset stall", int'(stall), 0);
        chk("R12 reset count", int'(stall_cycles), 0);

        // R1: integer to integer and to load base
        run(3'd0, 5'd3, 5'd0, 1'b0, 5'd0, 1'b0, "R1", n);
        run(3'd0, 5'd4, 5'd3, 1'b1, 5'd0, 1'b0, "R1", n); chk("R1 int->int stalls", n, 0);
        run(3'd2, 5'd2, 5'd4, 1'b1, 5'd0, 1'b0, "R1", n); chk("R1 int->load stalls", n, 0);
        idle(5);
        // R2: integer to branch
        run(3'd0, 5'd1, 5'd0, 1'b0, 5'd0, 1'b0, "R2", n);
        run(3'd1, 5'd0, 5'd1, 1'b1, 5'd0, 1'b0, "R2", n); chk("R2 int->br stalls", n, 1);
        // R3: load to FP ALU
        run(3'd2, 5'd2, 5'd1, 1'b1, 5'd0, 1'b0, "R3", n);
        run(3'd3, 5'd5, 5'd2, 1'b1, 5'd0, 1'b0, "R3", n); chk("R3 load->fadd stalls", n, 1);
        idle(5);
        // R4: add to FP ALU
        run(3'd3, 5'd6, 5'd1, 1'b1, 5'd1, 1'b1, "R4", n);
        run(3'd4, 5'd7, 5'd6, 1'b1, 5'd1, 1'b1, "R4", n); chk("R4 fadd->fmul stalls", n, 3);
        idle(5);
        // R5: multiply to FP ALU
        run(3'd4, 5'd6, 5'd1, 1'b1, 5'd1, 1'b1, "R5", n);
        run(3'd3, 5'd8, 5'd1, 1'b1, 5'd6, 1'b1, "R5", n); chk("R5 fmul->fadd stalls", n, 4);
        idle(5);
        // R6: separate files
        run(3'd0, 5'd7, 5'd0, 1'b0, 5'd0, 1'b0, "R6", n);
        run(3'd3, 5'd9, 5'd7, 1'b1, 5'd0, 1'b0, "R6", n); chk("R6 int R7 vs fp F7", n, 0);
        run(3'd4, 5'd9, 5'd1, 1'b1, 5'd0, 1'b0, "R6", n);
        run(3'd1, 5'd0, 5'd9, 1'b1, 5'd0, 1'b0, "R6", n); chk("R6 fp F9 vs branch R9", n, 0);
        idle(5);
        // R7: disabled source, branch writes nothing
        run(3'd4, 5'd10, 5'd1, 1'b1, 5'd0, 1'b0, "R7", n);
        run(3'd3, 5'd11, 5'd1, 1'b1, 5'd10, 1'b0, "R7", n); chk("R7 disabled src", n, 0);
        run(3'd1, 5'd12, 5'd0, 1'b0, 5'd0, 1'b0, "R7", n);
        run(3'd1, 5'd0, 5'd12, 1'b1, 5'd0, 1'b0, "R7", n); chk("R7 branch no dest", n, 0);
        idle(5);
        // R8: rewrite of a pending register keeps the later time
        run(3'd4, 5'd11, 5'd1, 1'b1, 5'd0, 1'b0, "R8", n);
        run(3'd2, 5'd11, 5'd1, 1'b1, 5'd0, 1'b0, "R8", n);
        run(3'd3, 5'd13, 5'd11, 1'b1, 5'd0, 1'b0, "R8", n); chk("R8 waw stalls", n, 3);
        idle(5);
        // R9: countdown runs during idle cycles
        run(3'd4, 5'd12, 5'd1, 1'b1, 5'd0, 1'b0, "R9", n);
        idle(4);
        run(3'd3, 5'd14, 5'd12, 1'b1, 5'd0, 1'b0, "R9", n); chk("R9 after idle", n, 0);
        // R10: reserved code
        run(3'd4, 5'd13, 5'd1, 1'b1, 5'd0, 1'b0, "R10", n);
        run(3'd5, 5'd15, 5'd13, 1'b1, 5'd13, 1'b1, "R10", n); chk("R10 reserved stalls", n, 0);
        run(3'd3, 5'd16, 5'd15, 1'b1, 5'd0, 1'b0, "R10", n); chk("R10 reserved no dest", n, 0);
        idle(5);
        // R13: a stalled producer marks at issue
        run(3'd4, 5'd15, 5'd1, 1'b1, 5'd0, 1'b0, "R13", n);
        run(3'd3, 5'd16, 5'd15, 1'b1, 5'd0, 1'b0, "R13", n); chk("R13 first wait", n, 4);
        run(3'd4, 5'd17, 5'd16, 1'b1, 5'd0, 1'b0, "R13", n); chk("R13 second wait", n, 3);
        idle(5);
        // R11: dot-product loop, three passes
        base = m_sc;
        for (int it = 0; it < 3; it++) begin
            run(3'd2, 5'd2, 5'd1, 1'b1, 5'd0, 1'b0, "R11", n); chk("R11 ld x", n, 0);
            run(3'd2, 5'd4, 5'd1, 1'b1, 5'd0, 1'b0, "R11", n); chk("R11 ld y", n, 0);
            run(3'd4, 5'd6, 5'd4, 1'b1, 5'd2, 1'b1, "R11", n); chk("R11 mul", n, 1);
            run(3'd3, 5'd0, 5'd0, 1'b1, 5'd6, 1'b1, "R11", n); chk("R11 add", n, 4);
            run(3'd0, 5'd1, 5'd1, 1'b1, 5'd0, 1'b0, "R11", n); chk("R11 sub", n, 0);
            run(3'd1, 5'd0, 5'd1, 1'b1, 5'd0, 1'b0, "R11", n); chk("R11 br", n, 1);
        end
        idle(1);
        chk("R11 loop total", int'(stall_cycles) - base, 18);
        // R12: reset mid-run
        run(3'd4, 5'd20, 5'd1, 1'b1, 5'd0, 1'b0, "R12", n);
        do_reset();
        #1;
        chk("R12 count cleared", int'(stall_cycles), 0);
        run(3'd3, 5'd21, 5'd20, 1'b1, 5'd0, 1'b0, "R12", n); chk("R12 ready after reset", n, 0);
        // Random stream against the model
        for (int k = 0; k < 400; k++) begin
            cycle(($urandom % 4) != 0, 3'($urandom % 7), 5'($urandom % 6),
                  5'($urandom % 6), 1'($urandom), 5'($urandom % 6), 1'($urandom),
                  "R1 random", iss, stl);
        end
        idle(1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule